// File: doc/BRIEF.md
# Translation Control System Register Access Unit

This block holds the 64-bit stage-1 translation control register for the kernel/user address regime. It also arbitrates every system-register read or write that names this register. Each request carries the five-field system encoding, the current exception level, the direction and write data. Control bits from the hypervisor and secure-monitor configuration arrive as plain inputs. From these the block picks exactly one outcome:

- finish the access on the local register,
- hand it to the hypervisor's own translation control register,
- send it to a memory-backed slot used for nested virtualization,
- raise a trap to the hypervisor with a syndrome class,
- report the instruction as undefined.

The response is registered and appears on the cycle after the request. The block only signals the memory slot and the trap; it does not implement them. Writes that land locally are cleaned before they are stored. Reserved bits are forced to zero, and a reserved granule code in either granule field is replaced by the code for the 4KB granule.

Top module: `xlat_ctl_sysreg`

## Requirements
- R1: After reset all response outputs are 0 and the stored register reads back as 0.
- R2: Only the primary encoding (op0=3, op1=0, CRn=2, CRm=0, op2=2) and the hypervisor alias (same but op1=5) produce a response, one cycle after the request. Any other encoding, including CRm=7/op2=6, produces no response.
- R3: A request for either encoding from exception level 0 reports undefined.
- R4: On the primary encoding at level 1 with the hypervisor enabled, a read with the coarse read-trap bit set, or a write with the coarse write-trap bit set, traps with syndrome class 0x18. The other direction's bit has no effect.
- R5: On the primary encoding at level 1, when no coarse trap applies, the access traps with class 0x18 if four conditions all hold. The fine-grained feature is present, the hypervisor is enabled, the secure monitor is absent or its fine-grained enable is 1, and the fine-grained bit for the direction is set.
- R6: On the primary encoding at level 1 with no trap, nested-mode bits 0b111 redirect to memory with slot offset 0x120. Traps take priority over the redirect.
- R7: On the primary encoding, level 2 in host mode redirects to the hypervisor register; level 2 otherwise, and level 3 always, complete locally.
- R8: On the alias at level 1 the outcome depends on the nested-mode bits. 0b101 redirects to memory at offset 0x120. Otherwise the access traps with class 0x18 if bit 0 is 1, and reports undefined if it is 0.
- R9: On the alias at levels 2 and 3, host mode completes locally; otherwise the access reports undefined.
- R10: At most one outcome output is high. Read data is the stored value on a local read and 0 in every other case.
- R11: Bits 63, 62, 35 and 6 always read as 0, whatever is written.
- R12: The granule code in bits [15:14] maps 0=4KB, 1=64KB, 2=16KB; a written 3 is stored as 0. The granule code in bits [31:30] maps 1=16KB, 2=4KB, 3=64KB; a written 0 is stored as 2.
- R13: A write whose outcome is not local leaves the stored register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Current exception level |
| req_wdata | input | 64 | Write data |
| hyp_enabled | input | 1 | Hypervisor level enabled |
| hyp_host_mode | input | 1 | Hypervisor runs a host kernel |
| hyp_rd_trap | input | 1 | Coarse read-trap bit |
| hyp_wr_trap | input | 1 | Coarse write-trap bit |
| fg_present | input | 1 | Fine-grained trap feature present |
| mon_present | input | 1 | Secure monitor level present |
| mon_fg_enable | input | 1 | Monitor enable for fine-grained traps |
| fg_rd_trap | input | 1 | Fine-grained read-trap bit for this register |
| fg_wr_trap | input | 1 | Fine-grained write-trap bit for this register |
| nest_mode | input | 3 | Nested-virtualization mode bits |
| rsp_done | output | 1 | Access completed locally |
| rsp_to_hyp_reg | output | 1 | Redirect to hypervisor register |
| rsp_to_mem | output | 1 | Redirect to memory slot |
| rsp_trap | output | 1 | Trap to hypervisor |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_rdata | output | 64 | Read data |
| rsp_syndrome | output | 6 | Syndrome class when trapping |
| rsp_mem_offset | output | 12 | Slot offset when redirected to memory |

## Verification
The assertions assume that a request strobe lasts one cycle and that the control inputs do not change in the cycle a request is sampled. They also assume `req_el` names a level that exists. The stimulus changes control inputs only between requests and follows each request with an idle cycle, so every response maps to one request. It walks each exception level through each control combination the requirements name, including the trap-versus-redirect priorities and the reserved granule codes.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

  localparam int DATA_W = 64;

  typedef enum logic [2:0] {
    OC_NONE  = 3'd0,
    OC_LOCAL = 3'd1,
    OC_HYP   = 3'd2,
    OC_MEM   = 3'd3,
    OC_TRAP  = 3'd4,
    OC_UNDEF = 3'd5
  } outcome_e;

  localparam logic [1:0] ENC_OP0      = 2'b11;
  localparam logic [2:0] ENC_OP1_MAIN = 3'b000;
  localparam logic [2:0] ENC_OP1_HYP  = 3'b101;
  localparam logic [3:0] ENC_CRN      = 4'b0010;
  localparam logic [3:0] ENC_CRM      = 4'b0000;
  localparam logic [2:0] ENC_OP2      = 3'b010;

  localparam logic [5:0]  TRAP_CLASS = 6'h18;
  localparam logic [11:0] SLOT_OFF   = 12'h120;

  localparam logic [2:0] NEST_FULL      = 3'b111;
  localparam logic [2:0] NEST_ALIAS_MEM = 3'b101;

  localparam int LO_GRAN_LSB = 14;
  localparam int HI_GRAN_LSB = 30;
  localparam logic [1:0] LO_GRAN_BAD = 2'b11;
  localparam logic [1:0] LO_GRAN_4K  = 2'b00;
  localparam logic [1:0] HI_GRAN_BAD = 2'b00;
  localparam logic [1:0] HI_GRAN_4K  = 2'b10;

  function automatic logic [DATA_W-1:0] rsv_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[63] = 1'b1;
    m[62] = 1'b1;
    m[35] = 1'b1;
    m[6]  = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] clean_write(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] v;
    v = w & ~rsv_mask();
    if (v[LO_GRAN_LSB +: 2] == LO_GRAN_BAD) v[LO_GRAN_LSB +: 2] = LO_GRAN_4K;
    if (v[HI_GRAN_LSB +: 2] == HI_GRAN_BAD) v[HI_GRAN_LSB +: 2] = HI_GRAN_4K;
    return v;
  endfunction

endpackage

// File: rtl/xlat_ctl_decode.sv
module xlat_ctl_decode
  import xlat_ctl_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit_main,
  output logic       hit_hyp
);
  logic common_ok;

  always_comb begin
    common_ok = valid && (op0 == ENC_OP0) && (crn == ENC_CRN) &&
                (crm == ENC_CRM) && (op2 == ENC_OP2);
    hit_main  = common_ok && (op1 == ENC_OP1_MAIN);
    hit_hyp   = common_ok && (op1 == ENC_OP1_HYP);
  end
endmodule

// File: rtl/xlat_ctl_policy.sv
module xlat_ctl_policy
  import xlat_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_main,
  input  logic     hit_hyp,
  input  logic     is_write,
  input  logic [1:0] el,
  input  logic     hyp_enabled,
  input  logic     hyp_host_mode,
  input  logic     hyp_rd_trap,
  input  logic     hyp_wr_trap,
  input  logic     fg_present,
  input  logic     mon_present,
  input  logic     mon_fg_enable,
  input  logic     fg_rd_trap,
  input  logic     fg_wr_trap,
  input  logic [2:0] nest_mode,
  output outcome_e outcome
);
  logic coarse_hit, fine_gate, fine_hit, nest_full, alias_mem, alias_trap;

  always_comb begin
    coarse_hit = hyp_enabled && (is_write ? hyp_wr_trap : hyp_rd_trap);
    fine_gate  = fg_present && hyp_enabled && (!mon_present || mon_fg_enable);
    fine_hit   = fine_gate && (is_write ? fg_wr_trap : fg_rd_trap);
    nest_full  = (nest_mode == NEST_FULL);
    alias_mem  = (nest_mode == NEST_ALIAS_MEM);
    alias_trap = nest_mode[0];
  end

  always_comb begin
    outcome = OC_NONE;
    if (hit_main) begin
      unique case (el)
        2'd0: outcome = OC_UNDEF;
        2'd1: begin
          if (coarse_hit)      outcome = OC_TRAP;
          else if (fine_hit)   outcome = OC_TRAP;
          else if (nest_full)  outcome = OC_MEM;
          else                 outcome = OC_LOCAL;
        end
        2'd2: outcome = hyp_host_mode ? OC_HYP : OC_LOCAL;
        default: outcome = OC_LOCAL;
      endcase
    end else if (hit_hyp) begin
      unique case (el)
        2'd0: outcome = OC_UNDEF;
        2'd1: begin
          if (alias_mem)       outcome = OC_MEM;
          else if (alias_trap) outcome = OC_TRAP;
          else                 outcome = OC_UNDEF;
        end
        default: outcome = hyp_host_mode ? OC_LOCAL : OC_UNDEF;
      endcase
    end
  end

  assert_el0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_main || hit_hyp) && el == 2'd0) |-> outcome == OC_UNDEF);

  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_main && !hit_hyp) |-> outcome == OC_NONE);

  assert_trap_beats_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_main && el == 2'd1 && coarse_hit && nest_full) |-> outcome == OC_TRAP);

  assert_el3_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_main && el == 2'd3) |-> outcome == OC_LOCAL);
endmodule

// File: rtl/xlat_ctl_store.sv
module xlat_ctl_store
  import xlat_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= clean_write(wdata);
  end

  assert_rsv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q & rsv_mask()) == '0);

  assert_lo_gran_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    q[LO_GRAN_LSB +: 2] != LO_GRAN_BAD);

  assert_hi_gran_fixed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q[HI_GRAN_LSB +: 2] != HI_GRAN_BAD);
endmodule

// File: rtl/xlat_ctl_sysreg.sv
module xlat_ctl_sysreg
  import xlat_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_op0,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [1:0]  req_el,
  input  logic [63:0] req_wdata,
  input  logic        hyp_enabled,
  input  logic        hyp_host_mode,
  input  logic        hyp_rd_trap,
  input  logic        hyp_wr_trap,
  input  logic        fg_present,
  input  logic        mon_present,
  input  logic        mon_fg_enable,
  input  logic        fg_rd_trap,
  input  logic        fg_wr_trap,
  input  logic [2:0]  nest_mode,
  output logic        rsp_done,
  output logic        rsp_to_hyp_reg,
  output logic        rsp_to_mem,
  output logic        rsp_trap,
  output logic        rsp_undef,
  output logic [63:0] rsp_rdata,
  output logic [5:0]  rsp_syndrome,
  output logic [11:0] rsp_mem_offset
);
  logic              hit_main, hit_hyp;
  outcome_e          outcome;
  logic              local_wr;
  logic [DATA_W-1:0] store_q;

  xlat_ctl_decode u_decode (
    .valid   (req_valid),
    .op0     (req_op0),
    .op1     (req_op1),
    .crn     (req_crn),
    .crm     (req_crm),
    .op2     (req_op2),
    .hit_main(hit_main),
    .hit_hyp (hit_hyp)
  );

  xlat_ctl_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_main     (hit_main),
    .hit_hyp      (hit_hyp),
    .is_write     (req_write),
    .el           (req_el),
    .hyp_enabled  (hyp_enabled),
    .hyp_host_mode(hyp_host_mode),
    .hyp_rd_trap  (hyp_rd_trap),
    .hyp_wr_trap  (hyp_wr_trap),
    .fg_present   (fg_present),
    .mon_present  (mon_present),
    .mon_fg_enable(mon_fg_enable),
    .fg_rd_trap   (fg_rd_trap),
    .fg_wr_trap   (fg_wr_trap),
    .nest_mode    (nest_mode),
    .outcome      (outcome)
  );

  assign local_wr = (outcome == OC_LOCAL) && req_write;

  xlat_ctl_store u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(local_wr),
    .wdata(req_wdata),
    .q    (store_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done       <= 1'b0;
      rsp_to_hyp_reg <= 1'b0;
      rsp_to_mem     <= 1'b0;
      rsp_trap       <= 1'b0;
      rsp_undef      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_syndrome   <= '0;
      rsp_mem_offset <= '0;
    end else begin
      rsp_done       <= (outcome == OC_LOCAL);
      rsp_to_hyp_reg <= (outcome == OC_HYP);
      rsp_to_mem     <= (outcome == OC_MEM);
      rsp_trap       <= (outcome == OC_TRAP);
      rsp_undef      <= (outcome == OC_UNDEF);
      rsp_rdata      <= (outcome == OC_LOCAL && !req_write) ? store_q : '0;
      rsp_syndrome   <= (outcome == OC_TRAP) ? TRAP_CLASS : '0;
      rsp_mem_offset <= (outcome == OC_MEM) ? SLOT_OFF : '0;
    end
  end

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_done, rsp_to_hyp_reg, rsp_to_mem, rsp_trap, rsp_undef}));

  assert_rdata_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> rsp_rdata == '0);

  assert_trap_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_syndrome == 6'h18);

  assert_slot_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_to_mem |-> rsp_mem_offset == 12'h120);

  assert_hold_on_redirect_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && outcome != OC_LOCAL) |=> $stable(store_q));

  assert_host_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_main && req_el == 2'd2 && hyp_host_mode) |=> rsp_to_hyp_reg);
endmodule

// File: tb/xlat_ctl_sysreg_bench.sv
module xlat_ctl_sysreg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_op0 = 0, req_el = 0;
  logic [2:0]  req_op1 = 0, req_op2 = 0, nest_mode = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [63:0] req_wdata = 0;
  logic hyp_enabled = 0, hyp_host_mode = 0, hyp_rd_trap = 0, hyp_wr_trap = 0;
  logic fg_present = 0, mon_present = 0, mon_fg_enable = 0, fg_rd_trap = 0, fg_wr_trap = 0;
  logic rsp_done, rsp_to_hyp_reg, rsp_to_mem, rsp_trap, rsp_undef;
  logic [63:0] rsp_rdata;
  logic [5:0]  rsp_syndrome;
  logic [11:0] rsp_mem_offset;

  xlat_ctl_sysreg u_xlat_ctl_sysreg (.*);

  typedef struct {
    logic [4:0]  flags;  // done, hyp, mem, trap, undef
    logic [63:0] rdata;
    logic [5:0]  cls;
    logic [11:0] off;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  logic [63:0] model_reg = '0;

  function automatic logic [63:0] model_clean(input logic [63:0] w);
    logic [63:0] v = w;
    v[63] = 0; v[62] = 0; v[35] = 0; v[6] = 0;
    if (v[15] && v[14]) v[15:14] = 2'b00;
    if (!v[31] && !v[30]) v[31:30] = 2'b10;
    return v;
  endfunction

  task automatic send(input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn,
                      input logic [3:0] cm, input logic [2:0] o2, input logic [1:0] el,
                      input logic wr, input logic [63:0] wd, input string tag);
    exp_t e;
    bit is_main, is_alias;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_op0 = o0; req_op1 = o1; req_crn = cn;
    req_crm = cm; req_op2 = o2; req_el = el; req_wdata = wd;
    is_main  = (o0 == 3 && o1 == 0 && cn == 2 && cm == 0 && o2 == 2);
    is_alias = (o0 == 3 && o1 == 5 && cn == 2 && cm == 0 && o2 == 2);
    e.flags = 5'b0; e.rdata = 0; e.cls = 0; e.off = 0; e.tag = tag;
    if (is_main || is_alias) begin
      if (el == 0) e.flags = 5'b00001;
      else if (is_main && el == 1) begin
        if (hyp_enabled && (wr ? hyp_wr_trap : hyp_rd_trap)) e.flags = 5'b00010;
        else if (fg_present && hyp_enabled && (mon_fg_enable || !mon_present) &&
                 (wr ? fg_wr_trap : fg_rd_trap)) e.flags = 5'b00010;
        else if (nest_mode == 3'b111) e.flags = 5'b00100;
        else e.flags = 5'b10000;
      end else if (is_main) begin
        e.flags = (el == 2 && hyp_host_mode) ? 5'b01000 : 5'b10000;
      end else if (el == 1) begin
        if (nest_mode == 3'b101) e.flags = 5'b00100;
        else if (nest_mode[0]) e.flags = 5'b00010;
        else e.flags = 5'b00001;
      end else begin
        e.flags = hyp_host_mode ? 5'b10000 : 5'b00001;
      end
    end
    if (e.flags == 5'b10000) begin
      if (wr) model_reg = model_clean(wd);
      else e.rdata = model_reg;
    end
    if (e.flags == 5'b00010) e.cls = 6'h18;
    if (e.flags == 5'b00100) e.off = 12'h120;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic acc(input bit alias_enc, input logic [1:0] el, input logic wr,
                     input logic [63:0] wd, input string tag);
    send(2'b11, alias_enc ? 3'b101 : 3'b000, 4'b0010, 4'b0000, 3'b010, el, wr, wd, tag);
  endtask

  task automatic ctl(input logic en, host, rt, wt, fgp, monp, monen, fgr, fgw,
                     input logic [2:0] nm);
    @(negedge clk);
    hyp_enabled = en; hyp_host_mode = host; hyp_rd_trap = rt; hyp_wr_trap = wt;
    fg_present = fgp; mon_present = monp; mon_fg_enable = monen;
    fg_rd_trap = fgr; fg_wr_trap = fgw; nest_mode = nm;
  endtask

  // monitor: one response per queued item, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic [86:0] act, expv;
        e = sb_q.pop_front();
        act  = {rsp_done, rsp_to_hyp_reg, rsp_to_mem, rsp_trap, rsp_undef,
                rsp_rdata, rsp_syndrome, rsp_mem_offset};
        expv = {e.flags, e.rdata, e.cls, e.off};
        checks++;
        if (act !== expv) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", e.tag, act, expv);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if ({rsp_done, rsp_to_hyp_reg, rsp_to_mem, rsp_trap, rsp_undef} !== 5'b0 ||
        rsp_rdata !== 0) begin
      errors++;
      $display("FAIL R1 actual=%b/%h expected=0/0",
               {rsp_done, rsp_to_hyp_reg, rsp_to_mem, rsp_trap, rsp_undef}, rsp_rdata);
    end
    acc(0, 3, 0, 0, "R1 reset read");
    // R11 R12: write with reserved bits and reserved granule codes at level 3
    acc(0, 3, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R11 write all ones");
    acc(0, 3, 0, 0, "R11 R12 read back cleaned");
    acc(0, 3, 1, 64'h0000_0000_0000_4000, "R12 hi granule zero");
    acc(0, 3, 0, 0, "R12 read back hi granule fixed");
    acc(0, 3, 1, 64'h1234_5678_9ABC_8DEF, "R12 legal granules");
    acc(0, 3, 0, 0, "R12 read back legal granules");
    // R3
    acc(0, 0, 0, 0, "R3 main read at level 0");
    acc(1, 0, 1, 64'h55, "R3 alias write at level 0");
    // R2
    send(2'b11, 3'b000, 4'b0010, 4'b0000, 3'b011, 1, 0, 0, "R2 foreign op2");
    send(2'b11, 3'b000, 4'b0010, 4'b0111, 3'b110, 1, 0, 0, "R2 masked alias silent");
    send(2'b10, 3'b000, 4'b0010, 4'b0000, 3'b010, 3, 1, 64'hDEAD, "R2 foreign op0");
    acc(0, 3, 0, 0, "R2 foreign write did not land");
    // R4
    ctl(1, 0, 1, 0, 0, 0, 0, 0, 0, 3'b000);
    acc(0, 1, 0, 0, "R4 coarse read trap");
    acc(0, 1, 1, 64'h0000_0000_8000_0010, "R4 write ignores read-trap bit");
    ctl(1, 0, 0, 1, 0, 0, 0, 0, 0, 3'b000);
    acc(0, 1, 1, 64'hAAAA, "R4 coarse write trap");
    acc(0, 1, 0, 0, "R13 trapped write left register");
    ctl(0, 0, 1, 1, 0, 0, 0, 0, 0, 3'b000);
    acc(0, 1, 0, 0, "R4 hypervisor disabled no trap");
    // R5
    ctl(1, 0, 0, 0, 1, 1, 0, 1, 1, 3'b000);
    acc(0, 1, 0, 0, "R5 monitor enable off");
    ctl(1, 0, 0, 0, 1, 1, 1, 1, 0, 3'b000);
    acc(0, 1, 0, 0, "R5 fine read trap");
    acc(0, 1, 1, 64'h8000_4003, "R5 fine write bit clear");
    ctl(1, 0, 0, 0, 1, 0, 0, 0, 1, 3'b000);
    acc(0, 1, 1, 64'h1, "R5 monitor absent write trap");
    ctl(1, 0, 0, 0, 0, 0, 0, 1, 1, 3'b000);
    acc(0, 1, 0, 0, "R5 feature absent");
    // R6
    ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b111);
    acc(0, 1, 1, 64'h77, "R6 nested redirect");
    ctl(1, 0, 1, 0, 0, 0, 0, 0, 0, 3'b111);
    acc(0, 1, 0, 0, "R6 trap beats redirect");
    acc(0, 3, 0, 0, "R13 redirected write left register");
    // R7
    ctl(1, 1, 0, 0, 0, 0, 0, 0, 0, 3'b000);
    acc(0, 2, 0, 0, "R7 host level 2");
    acc(0, 3, 0, 0, "R7 host level 3 local");
    ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000);
    acc(0, 2, 1, 64'h4000_0000_0000_0020, "R7 level 2 non-host write");
    acc(0, 2, 0, 0, "R7 level 2 read back");
    // R8
    ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b101);
    acc(1, 1, 0, 0, "R8 alias 101 memory");
    ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b001);
    acc(1, 1, 0, 0, "R8 alias 001 trap");
    ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b111);
    acc(1, 1, 1, 64'h9, "R8 alias 111 trap");
    ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b110);
    acc(1, 1, 0, 0, "R8 alias 110 undefined");
    ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000);
    acc(1, 1, 0, 0, "R8 alias 000 undefined");
    // R9
    acc(1, 2, 0, 0, "R9 alias level 2 non-host");
    ctl(1, 1, 0, 0, 0, 0, 0, 0, 0, 3'b000);
    acc(1, 3, 1, 64'h0000_0008_C000_C0C1, "R9 alias level 3 host write");
    acc(1, 2, 0, 0, "R9 R10 alias level 2 host read");
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule